// File: doc/BRIEF.md
# Memory Error Address and Status Logger

This block sits beside a memory that corrects single-bit errors and detects double-bit errors. On every access it receives a valid strobe, the access address and two classification flags from the correction logic. It keeps the first error it sees: the error's address goes into an address register, and a summary of the error goes into a status register. The summary holds a valid flag, a single-or-double flag and a saturating count of the errors that arrived after the first one was caught.

While no error is held, the address register follows the address of every valid access, so software can always read back the most recent location touched. Software reads the status register and pulses a read strobe in the same cycle. That read clears the capture and arms it for the next error. A small control register enables an interrupt for single-bit errors and, separately, for double-bit errors. It also drives a signal that turns error correction off. An enabled capture raises a one-cycle request on the most significant bit of an interrupt word, which is the highest-priority channel.

Top module: `mem_err_logger`

## Requirements
- R1: A valid access with either error flag set, while nothing is held, loads its address into the address register and sets the status valid flag (status bit 5) with a count of zero on the next clock edge. An error flag on a cycle without valid has no effect.
- R2: While nothing is held, the address register takes the address of every valid error-free access on the next edge. While an error is held, the address register keeps the captured address.
- R3: Later errors never overwrite the held address or the single/double flag (status bit 4, 1 = double). An access with both flags set counts as double.
- R4: A status read strobe with no error in the same cycle clears the whole status word to zero on the next edge.
- R5: Each error that arrives while one is held adds one to the count field (status bits 3..0). The count saturates at its maximum of 15.
- R6: A control write stores three bits: bit 0 enables the single-bit interrupt, bit 1 enables the double-bit interrupt, and bit 2 disables correction, which is also driven on its own output. All three reset to zero.
- R7: A capture raises bit 15 of the interrupt word for exactly one cycle, aligned with the status valid flag rising. This happens only if the captured kind is enabled. All other bits of the interrupt word stay zero.
- R8: An error in the same cycle as a status read is captured after the clear. It is not lost: its address, kind and a count of zero are held afterwards.
- R9: After reset the address, status, control, correction-disable and interrupt outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid_i | input | 1 | A memory access completes this cycle |
| acc_addr_i | input | AW | Address of the access |
| acc_sbe_i | input | 1 | Correction logic reports a single-bit error |
| acc_dbe_i | input | 1 | Correction logic reports a double-bit error |
| stat_rd_i | input | 1 | Software reads the status register this cycle |
| ctl_we_i | input | 1 | Write strobe for the control register |
| ctl_wdata_i | input | 3 | Control value to store |
| err_addr_o | output | AW | Address register |
| err_stat_o | output | CW+2 | Status: {valid, double, count} |
| ctl_o | output | 3 | Control register contents |
| corr_disable_o | output | 1 | Error correction turned off |
| irq_word_o | output | IW | Interrupt word; only the top bit is used |

## Verification
Some properties are checked by assertions on every cycle. The held address and the held error kind stay stable until a read. An error with nothing held always produces a valid capture. A read with no error always clears the capture. A saturated count stays at its maximum. An interrupt request only appears while a capture is held. Other behaviours need the bench's scenarios to show them. These are the exact address tracking across clean accesses, how the interrupt is gated by each enable bit, and the read-and-error collision in a single cycle. The bench also covers an access with both flags set, and error flags that arrive without valid.

// File: rtl/mel_pkg.sv
package mel_pkg;

    typedef enum logic [1:0] {
        EK_NONE   = 2'd0,
        EK_SINGLE = 2'd1,
        EK_DOUBLE = 2'd2
    } err_kind_e;

    typedef struct packed {
        logic no_corr;
        logic dbl_irq_en;
        logic sgl_irq_en;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic err_kind_e classify(input logic valid,
                                           input logic sgl,
                                           input logic dbl);
        if (!valid)
            return EK_NONE;
        else if (dbl)
            return EK_DOUBLE;
        else if (sgl)
            return EK_SINGLE;
        else
            return EK_NONE;
    endfunction

    function automatic logic kind_enabled(input err_kind_e kind, input ctl_t ctl);
        case (kind)
            EK_SINGLE: return ctl.sgl_irq_en;
            EK_DOUBLE: return ctl.dbl_irq_en;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mel_ctl_reg.sv
module mel_ctl_reg
    import mel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl_q
);

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (we)
            ctl_q <= ctl_t'(wdata);
    end

    AST_CTL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(ctl_q)); // R6

endmodule

// File: rtl/mel_capture.sv
module mel_capture
    import mel_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_addr,
    input  err_kind_e     kind,
    input  logic          stat_rd,
    output logic [AW-1:0] addr_q,
    output logic          held_q,
    output logic          dbl_q,
    output logic [CW-1:0] cnt_q,
    output logic          capture
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic eff_held;
    logic is_err;

    assign eff_held = held_q && !stat_rd;
    assign is_err   = (kind != EK_NONE);
    assign capture  = is_err && !eff_held;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            held_q <= 1'b0;
            dbl_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (stat_rd) begin
                held_q <= 1'b0;
                dbl_q  <= 1'b0;
                cnt_q  <= '0;
            end
            if (capture) begin
                held_q <= 1'b1;
                dbl_q  <= (kind == EK_DOUBLE);
                cnt_q  <= '0;
            end else if (is_err && eff_held && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (acc_valid && !eff_held)
                addr_q <= acc_addr;
        end
    end

    AST_ADDR_KEPT: assert property (@(posedge clk) disable iff (rst)
        held_q && !stat_rd |=> $stable(addr_q)); // R2
    AST_KIND_KEPT: assert property (@(posedge clk) disable iff (rst)
        held_q && !stat_rd |=> held_q && $stable(dbl_q)); // R3
    AST_ERR_CAPTURED: assert property (@(posedge clk) disable iff (rst)
        is_err && !held_q |=> held_q && cnt_q == '0); // R1
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        stat_rd && !is_err |=> !held_q && !dbl_q && cnt_q == '0); // R4
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
        held_q && !stat_rd && cnt_q == CNT_MAX |=> cnt_q == CNT_MAX); // R5

endmodule

// File: rtl/mel_irq_gen.sv
module mel_irq_gen
    import mel_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      capture,
    input  err_kind_e kind,
    input  ctl_t      ctl,
    output logic      irq_q
);

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= capture && kind_enabled(kind, ctl);
    end

    AST_IRQ_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        !capture |=> !irq_q); // R7

endmodule

// File: rtl/mem_err_logger.sv
module mem_err_logger
    import mel_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 4,
    parameter int IW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid_i,
    input  logic [AW-1:0]    acc_addr_i,
    input  logic             acc_sbe_i,
    input  logic             acc_dbe_i,
    input  logic             stat_rd_i,
    input  logic             ctl_we_i,
    input  logic [CTL_W-1:0] ctl_wdata_i,
    output logic [AW-1:0]    err_addr_o,
    output logic [CW+1:0]    err_stat_o,
    output logic [CTL_W-1:0] ctl_o,
    output logic             corr_disable_o,
    output logic [IW-1:0]    irq_word_o
);

    localparam int IRQ_BIT = IW - 1;

    err_kind_e     kind;
    ctl_t          ctl;
    logic          held;
    logic          dbl;
    logic [CW-1:0] cnt;
    logic          capture;
    logic          irq;

    assign kind = classify(acc_valid_i, acc_sbe_i, acc_dbe_i);

    mel_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_we_i),
        .wdata (ctl_wdata_i),
        .ctl_q (ctl)
    );

    mel_capture #(.AW(AW), .CW(CW)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid_i),
        .acc_addr  (acc_addr_i),
        .kind      (kind),
        .stat_rd   (stat_rd_i),
        .addr_q    (err_addr_o),
        .held_q    (held),
        .dbl_q     (dbl),
        .cnt_q     (cnt),
        .capture   (capture)
    );

    mel_irq_gen u_irq (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .kind    (kind),
        .ctl     (ctl),
        .irq_q   (irq)
    );

    assign err_stat_o     = {held, dbl, cnt};
    assign ctl_o          = ctl;
    assign corr_disable_o = ctl.no_corr;

    always_comb begin
        irq_word_o          = '0;
        irq_word_o[IRQ_BIT] = irq;
    end

    AST_IRQ_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        irq |-> held); // R7
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq && !stat_rd_i |=> !irq); // R7

endmodule

// File: tb/mem_err_logger_test.sv
module mem_err_logger_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid_i = 1'b0;
    logic [15:0] acc_addr_i = '0;
    logic        acc_sbe_i = 1'b0;
    logic        acc_dbe_i = 1'b0;
    logic        stat_rd_i = 1'b0;
    logic        ctl_we_i = 1'b0;
    logic [2:0]  ctl_wdata_i = '0;
    logic [15:0] err_addr_o;
    logic [5:0]  err_stat_o;
    logic [2:0]  ctl_o;
    logic        corr_disable_o;
    logic [15:0] irq_word_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] addr;
        logic [5:0]  stat;
        logic [15:0] irq;
        logic        corr;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    mem_err_logger uut (
        .clk            (clk),
        .rst            (rst),
        .acc_valid_i    (acc_valid_i),
        .acc_addr_i     (acc_addr_i),
        .acc_sbe_i      (acc_sbe_i),
        .acc_dbe_i      (acc_dbe_i),
        .stat_rd_i      (stat_rd_i),
        .ctl_we_i       (ctl_we_i),
        .ctl_wdata_i    (ctl_wdata_i),
        .err_addr_o     (err_addr_o),
        .err_stat_o     (err_stat_o),
        .ctl_o          (ctl_o),
        .corr_disable_o (corr_disable_o),
        .irq_word_o     (irq_word_o)
    );

    task automatic cmp(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [15:0] a, input logic s,
                        input logic d, input logic rd, input logic we,
                        input logic [2:0] wd, input logic [15:0] ea,
                        input logic [5:0] es, input logic ei, input logic ec,
                        input string tag);
        exp_t e;
        @(negedge clk);
        acc_valid_i = v;  acc_addr_i = a;  acc_sbe_i = s;  acc_dbe_i = d;
        stat_rd_i = rd;   ctl_we_i = we;   ctl_wdata_i = wd;
        e.addr = ea;  e.stat = es;  e.irq = ei ? 16'h8000 : 16'h0000;
        e.corr = ec;  e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares after the edge that applied each pushed step
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                cmp(e.tag, "addr", err_addr_o, e.addr);
                cmp(e.tag, "stat", {10'd0, err_stat_o}, {10'd0, e.stat});
                cmp(e.tag, "irq", irq_word_o, e.irq);
                cmp(e.tag, "corr", {15'd0, corr_disable_o}, {15'd0, e.corr});
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        cmp("R9", "addr", err_addr_o, 16'h0);
        cmp("R9", "stat", {10'd0, err_stat_o}, 16'h0);
        cmp("R9", "ctl", {13'd0, ctl_o}, 16'h0);
        cmp("R9", "irq", irq_word_o, 16'h0);
        cmp("R9", "corr", {15'd0, corr_disable_o}, 16'h0);

        // R6 enable single-bit interrupt only
        step(0, 16'h0, 0, 0, 0, 1, 3'b001, 16'h0000, 6'h00, 0, 0, "R6");
        // R2 address follows clean accesses
        step(1, 16'h1234, 0, 0, 0, 0, 3'b0, 16'h1234, 6'h00, 0, 0, "R2");
        step(1, 16'h2000, 0, 0, 0, 0, 3'b0, 16'h2000, 6'h00, 0, 0, "R2");
        // R1 / R7 first single error captured, interrupt enabled
        step(1, 16'h0ABC, 1, 0, 0, 0, 3'b0, 16'h0ABC, 6'h20, 1, 0, "R1_R7");
        // R2 held address not replaced by clean access
        step(1, 16'h0555, 0, 0, 0, 0, 3'b0, 16'h0ABC, 6'h20, 0, 0, "R2");
        // R3 / R5 later double error only counts
        step(1, 16'h0777, 0, 1, 0, 0, 3'b0, 16'h0ABC, 6'h21, 0, 0, "R3_R5");
        // R5 saturation of the count
        for (int i = 0; i < 20; i++) begin
            int c;
            c = (i + 2 > 15) ? 15 : i + 2;
            step(1, 16'h1000 + 16'(i), i[0], !i[0], 0, 0, 3'b0,
                 16'h0ABC, {2'b10, 4'(c)}, 0, 0, "R5");
        end
        // R4 read clears
        step(0, 16'h0, 0, 0, 1, 0, 3'b0, 16'h0ABC, 6'h00, 0, 0, "R4");
        step(1, 16'h0100, 0, 0, 0, 0, 3'b0, 16'h0100, 6'h00, 0, 0, "R2");
        // R6 double interrupt on, correction off
        step(0, 16'h0, 0, 0, 0, 1, 3'b110, 16'h0100, 6'h00, 0, 1, "R6");
        // R7 single error captured but not enabled
        step(1, 16'h0200, 1, 0, 0, 0, 3'b0, 16'h0200, 6'h20, 0, 1, "R7");
        // R8 read and double error in one cycle
        step(1, 16'h0300, 0, 1, 1, 0, 3'b0, 16'h0300, 6'h30, 1, 1, "R8");
        // R3 both flags while held: count only
        step(1, 16'h0400, 1, 1, 0, 0, 3'b0, 16'h0300, 6'h31, 0, 1, "R3");
        step(0, 16'h0, 0, 0, 1, 0, 3'b0, 16'h0300, 6'h00, 0, 1, "R4");
        // R1 flags without valid ignored
        step(0, 16'h0999, 1, 1, 0, 0, 3'b0, 16'h0300, 6'h00, 0, 1, "R1");
        // R3 both flags counts as double
        step(1, 16'h0444, 1, 1, 0, 0, 3'b0, 16'h0444, 6'h30, 1, 1, "R3");
        // R4 / R2 read with a clean access: cleared and address follows
        step(1, 16'h0555, 0, 0, 1, 0, 3'b0, 16'h0555, 6'h00, 0, 1, "R4");
        step(0, 16'h0, 0, 0, 0, 0, 3'b0, 16'h0555, 6'h00, 0, 1, "R7");

        repeat (3) @(posedge clk);
        #3;
        cmp("R6", "ctl", {13'd0, ctl_o}, 16'h0006);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule